// File: doc/BRIEF.md
# Per-Vector Interrupt Cause and Mask Bank

This block keeps one byte for each message-signalled interrupt vector. The byte records why the vector last fired and also acts as that vector's mask. Device-side logic raises per-vector event lines of two kinds, receive/transmit activity and link state change. When an event reaches a vector whose byte is zero, the block does two things. It writes the cause code into the byte, which masks the vector. It also emits a one-cycle request pulse that names the vector and the cause. A later stage turns that pulse into the actual message write.

While the byte is nonzero, new events on that vector are held in a per-vector pending flag. The host re-enables a vector by writing zero to its byte through a simple register port. A pending event then fires as soon as the byte reads zero. When the auto-mask input is high, the bank is bypassed: events produce requests without checking or writing the bytes.

Only one request leaves the block per cycle. When several vectors are ready at once, the lowest index goes first and the rest wait as pending.

Top module: `irq_cause_mask`

## Requirements
- R1: After a synchronous reset, every cause byte is zero, no vector is pending, `irq_valid` is low and `host_rdata` is zero.
- R2: With auto-mask off, an event on a vector whose byte is zero produces, one clock later, a single-cycle `irq_valid` pulse carrying that vector in `irq_vec` and the cause code in `irq_cause`. The same code is stored in the byte. The codes are: 1 for receive/transmit activity, 2 for link state change.
- R3: An event on a vector whose byte is nonzero produces no request and leaves the byte unchanged. The event is remembered as pending for that vector.
- R4: A host write of zero to a byte re-enables the vector. If that vector is pending, its request appears on the second clock after the write.
- R5: A host write of a nonzero value stores that value and masks the vector. Later events only become pending.
- R6: When a host write and an event hit the same vector in the same cycle, the written value is stored and the event becomes pending instead of firing in that cycle.
- R7: At most one request is issued per cycle. Among ready vectors the lowest index fires first, and the others remain pending and fire in ascending order on later cycles.
- R8: With auto-mask on, each event produces a request regardless of the byte value, and the byte is not modified by the event.
- R9: `host_rdata` presents, one clock after `host_addr` is applied, the byte value held at that address before that clock's update.
- R10: A link-state event and a receive/transmit event on the same vector, whether in one cycle or held together as pending, resolve to code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mask_en | input | 1 | High: events bypass the cause bank |
| evt_rxtx | input | NUM_VEC | Per-vector receive/transmit activity event |
| evt_link | input | NUM_VEC | Per-vector link state change event |
| host_addr | input | clog2(NUM_VEC) | Host byte index, used for both read and write |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | CAUSE_W | Host write data |
| host_rdata | output | CAUSE_W | Registered read data |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vec | output | clog2(NUM_VEC) | Vector of the request |
| irq_cause | output | CAUSE_W | Cause code of the request |

## Verification
The bench targets these corner cases:
- A pending event that must fire only after the host zeroes the byte. A design that dropped pending events would never fire here. One that ignored the mask would fire early.
- A host write and an event landing on the same byte in the same cycle. A design that gave the event priority would store the cause and lose the host value.
- Three vectors ready at once. They must come out as three separate pulses in ascending order. A wrong arbiter would reorder them or merge them into one.
- Auto-mask mode, where a nonzero byte must neither block the event nor be overwritten by it.
- The link-over-activity merge of cause codes.

A long constrained-random run compares every cycle against a bench model.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_RXTX = 2'd1;
  localparam logic [1:0] CODE_LINK = 2'd2;

  // Higher code wins: link change outranks plain activity.
  function automatic logic [1:0] merge_code(logic [1:0] a, logic [1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   grant,
  output logic [AW-1:0]  idx,
  output logic           any
);
  logic [N:0] lower_busy;
  assign lower_busy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]        = req[i] & ~lower_busy[i];
    assign lower_busy[i+1] = lower_busy[i] | req[i];
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

  assign any = lower_busy[N];

  // R7: a single winner per cycle
  assert_one_winner_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R7: the winner was requesting and the index names it
  assert_winner_requested_R7: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && grant[idx]));
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags
  import irq_cause_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][1:0]   evt_code,
  input  logic [N-1:0]        clear,
  output logic [N-1:0][1:0]   merged
);
  logic [N-1:0][1:0] pend_q;

  for (genvar v = 0; v < N; v++) begin : g_merge
    assign merged[v] = merge_code(pend_q[v], evt_code[v]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      for (int v = 0; v < N; v++) begin
        pend_q[v] <= clear[v] ? CODE_NONE : merged[v];
      end
    end
  end

  for (genvar v = 0; v < N; v++) begin : g_chk
    // R10: an unserved link event is held as link, never downgraded
    assert_link_held_R10: assert property (@(posedge clk) disable iff (rst)
      (evt_code[v] == CODE_LINK && !clear[v]) |=> (pend_q[v] == CODE_LINK));
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_data,
  output logic [W-1:0]       rd_data,
  input  logic [N-1:0]       set_en,
  input  logic [N-1:0][1:0]  set_code,
  output logic [N-1:0]       is_zero
);
  logic [W-1:0] mem [N];
  logic [N-1:0] hit;

  for (genvar v = 0; v < N; v++) begin : g_flags
    assign hit[v]     = wr_en && (addr == AW'(v));
    assign is_zero[v] = (mem[v] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < N; v++) mem[v] <= '0;
      rd_data <= '0;
    end else begin
      for (int v = 0; v < N; v++) begin
        if (hit[v])          mem[v] <= wr_data;
        else if (set_en[v])  mem[v] <= W'(set_code[v]);
      end
      rd_data <= (int'(addr) < N) ? mem[addr] : '0;
    end
  end

  for (genvar v = 0; v < N; v++) begin : g_chk
    // R3: the block only ever stores a cause into an unmasked byte
    assert_set_only_zero_R3: assert property (@(posedge clk) disable iff (rst)
      set_en[v] |-> is_zero[v]);
    // R5: a byte nobody touches keeps its value
    assert_untouched_stable_R5: assert property (@(posedge clk) disable iff (rst)
      (!hit[v] && !set_en[v]) |=> $stable(mem[v]));
  end
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_cause_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int CAUSE_W = 8,
  localparam int AW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               auto_mask_en,
  input  logic [NUM_VEC-1:0] evt_rxtx,
  input  logic [NUM_VEC-1:0] evt_link,
  input  logic [AW-1:0]      host_addr,
  input  logic               host_we,
  input  logic [CAUSE_W-1:0] host_wdata,
  output logic [CAUSE_W-1:0] host_rdata,
  output logic               irq_valid,
  output logic [AW-1:0]      irq_vec,
  output logic [CAUSE_W-1:0] irq_cause
);
  logic [NUM_VEC-1:0][1:0] evt_code;
  logic [NUM_VEC-1:0][1:0] merged;
  logic [NUM_VEC-1:0]      host_hit;
  logic [NUM_VEC-1:0]      bank_zero;
  logic [NUM_VEC-1:0]      ready;
  logic [NUM_VEC-1:0]      grant;
  logic [NUM_VEC-1:0]      store_en;
  logic [AW-1:0]           pick_idx;
  logic                    pick_any;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign evt_code[v] = evt_link[v] ? CODE_LINK : (evt_rxtx[v] ? CODE_RXTX : CODE_NONE);
    assign host_hit[v] = host_we && (host_addr == AW'(v));
    assign ready[v]    = (merged[v] != CODE_NONE) && !host_hit[v] &&
                         (auto_mask_en || bank_zero[v]);
    assign store_en[v] = grant[v] && !auto_mask_en;
  end

  irq_pend_flags #(.N(NUM_VEC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt_code (evt_code),
    .clear    (grant),
    .merged   (merged)
  );

  irq_lowest_pick #(.N(NUM_VEC), .AW(AW)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (ready),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  irq_cause_bank #(.N(NUM_VEC), .W(CAUSE_W), .AW(AW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .addr     (host_addr),
    .wr_en    (host_we),
    .wr_data  (host_wdata),
    .rd_data  (host_rdata),
    .set_en   (store_en),
    .set_code (merged),
    .is_zero  (bank_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_cause <= '0;
    end else begin
      irq_valid <= pick_any;
      irq_vec   <= pick_idx;
      irq_cause <= CAUSE_W'(merged[pick_idx]);
    end
  end

  // R2: every request carries one of the two defined cause codes
  assert_cause_code_R2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_cause == CAUSE_W'(CODE_RXTX) || irq_cause == CAUSE_W'(CODE_LINK)));
  // R2: in banked mode the fired vector is masked from then on
  assert_fire_masks_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !$past(auto_mask_en)) |-> !bank_zero[irq_vec]);
endmodule

// File: tb/irq_cause_mask_test.sv
module irq_cause_mask_test;
  localparam int N        = 16;
  localparam int W        = 8;
  localparam int AW       = 4;
  localparam int CLK_HALF = 5;

  logic          clk = 0;
  logic          rst = 1;
  logic          auto_mask_en = 0;
  logic [N-1:0]  evt_rxtx = '0;
  logic [N-1:0]  evt_link = '0;
  logic [AW-1:0] host_addr = '0;
  logic          host_we = 0;
  logic [W-1:0]  host_wdata = '0;
  logic [W-1:0]  host_rdata;
  logic          irq_valid;
  logic [AW-1:0] irq_vec;
  logic [W-1:0]  irq_cause;

  int tests = 0;
  int fails = 0;
  int mb [N];
  int mp [N];
  int exp_valid, exp_vec, exp_cause, exp_rd;

  always #CLK_HALF clk = ~clk;

  irq_cause_mask #(.NUM_VEC(N), .CAUSE_W(W)) uut (
    .clk(clk), .rst(rst), .auto_mask_en(auto_mask_en),
    .evt_rxtx(evt_rxtx), .evt_link(evt_link),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_cause(irq_cause)
  );

  function automatic int code_of(bit rx, bit lk);
    return lk ? 2 : (rx ? 1 : 0);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Drive one cycle, advance the model, compare outputs after the edge.
  task automatic step(string tag, logic [N-1:0] rx, logic [N-1:0] lk,
                      bit we, int addr, int wd, bit au);
    int mg [N];
    int g;
    @(negedge clk);
    evt_rxtx = rx; evt_link = lk; host_we = we;
    host_addr = AW'(addr); host_wdata = W'(wd); auto_mask_en = au;
    g = -1;
    for (int v = 0; v < N; v++) begin
      bit hit;
      mg[v] = max2(mp[v], code_of(rx[v], lk[v]));
      hit = we && (addr == v);
      if (g < 0 && mg[v] != 0 && !hit && (au || mb[v] == 0)) g = v;
    end
    exp_rd = mb[addr];
    exp_valid = (g >= 0);
    exp_vec = (g >= 0) ? g : 0;
    exp_cause = (g >= 0) ? mg[g] : 0;
    for (int v = 0; v < N; v++) begin
      if (we && addr == v) mb[v] = wd;
      else if (v == g && !au) mb[v] = mg[v];
      mp[v] = (v == g) ? 0 : mg[v];
    end
    @(posedge clk);
    #1;
    chk({tag, " irq_valid"}, int'(irq_valid), exp_valid);
    if (exp_valid != 0) begin
      chk({tag, " irq_vec"}, int'(irq_vec), exp_vec);
      chk({tag, " irq_cause"}, int'(irq_cause), exp_cause);
    end
    chk({tag, " host_rdata"}, int'(host_rdata), exp_rd);
  endtask

  task automatic idle(string tag, int addr);
    step(tag, '0, '0, 0, addr, 0, 0);
  endtask

  function automatic logic [N-1:0] bit1(int v);
    logic [N-1:0] r;
    r = '0;
    r[v] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1357);
    for (int v = 0; v < N; v++) begin mb[v] = 0; mp[v] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1: reset state
    chk("R1 irq_valid after reset", int'(irq_valid), 0);
    chk("R1 host_rdata after reset", int'(host_rdata), 0);
    idle("R1 idle", 5);

    // R2: activity on unmasked vector 3
    step("R2 fire", bit1(3), '0, 0, 3, 0, 0);
    chk("R2 vector", int'(irq_vec), 3);
    chk("R2 cause code 1", int'(irq_cause), 1);
    idle("R2 pulse ends", 3);
    chk("R2 single-cycle pulse", int'(irq_valid), 0);
    // R9: the read registered in the previous step shows code 1
    chk("R9 read of byte 3", int'(host_rdata), 1);

    // R3: masked vector does not fire
    step("R3 masked", bit1(3), '0, 0, 3, 0, 0);
    chk("R3 no request", int'(irq_valid), 0);
    idle("R3 byte kept", 3);
    chk("R3 byte unchanged", int'(host_rdata), 1);

    // R4: clear re-enables; pending fires on the second clock
    step("R4 clear", '0, '0, 1, 3, 0, 0);
    chk("R4 not yet", int'(irq_valid), 0);
    idle("R4 fire", 0);
    chk("R4 pending fires", int'(irq_valid), 1);
    chk("R4 vector", int'(irq_vec), 3);

    // R10 / R2: both kinds together give code 2
    step("R10 merge", bit1(5), bit1(5), 0, 5, 0, 0);
    chk("R10 cause 2", int'(irq_cause), 2);

    // R5: host masks vector 7 with a nonzero value
    step("R5 write", '0, '0, 1, 7, 8'h40, 0);
    step("R5 masked event", bit1(7), '0, 0, 7, 0, 0);
    chk("R5 no request", int'(irq_valid), 0);
    idle("R5 read", 7);
    chk("R5 host value kept", int'(host_rdata), 8'h40);

    // R6: write and event on the same byte in the same cycle
    step("R6 collide", bit1(9), '0, 1, 9, 8'h11, 0);
    chk("R6 no request", int'(irq_valid), 0);
    idle("R6 read", 9);
    chk("R6 host value stored", int'(host_rdata), 8'h11);
    step("R6 clear", '0, '0, 1, 9, 0, 0);
    idle("R6 pending fires", 0);
    chk("R6 fires after clear", int'(irq_vec), 9);

    // R7: three ready vectors leave in ascending order
    step("R7 burst", bit1(14) | bit1(10) | bit1(12), '0, 0, 0, 0, 0);
    chk("R7 first", int'(irq_vec), 10);
    idle("R7 second", 0);
    chk("R7 second", int'(irq_vec), 12);
    idle("R7 third", 0);
    chk("R7 third", int'(irq_vec), 14);
    idle("R7 drained", 0);
    chk("R7 drained", int'(irq_valid), 0);

    // R8: auto mode fires through a nonzero byte and leaves it alone
    step("R8 auto fire", bit1(7), '0, 0, 7, 0, 1);
    chk("R8 request", int'(irq_valid), 1);
    chk("R8 vector", int'(irq_vec), 7);
    step("R8 read", '0, '0, 0, 7, 0, 1);
    chk("R8 byte untouched", int'(host_rdata), 8'h40);

    // R10: pending activity upgraded by a later link event
    step("R10 pend rx", bit1(3), '0, 0, 0, 0, 0);
    step("R10 pend link", '0, bit1(3), 0, 0, 0, 0);
    step("R10 clear", bit1(3), '0, 1, 3, 0, 0);
    idle("R10 fire", 3);
    chk("R10 pending link wins", int'(irq_cause), 2);

    // Random phase: checked cycle by cycle against the model
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] rx, lk;
      bit we, au;
      int a, d;
      rx = '0; lk = '0;
      for (int v = 0; v < N; v++) begin
        rx[v] = ($urandom % 12) == 0;
        lk[v] = ($urandom % 30) == 0;
      end
      we = ($urandom % 3) == 0;
      a  = $urandom % N;
      d  = (($urandom % 3) == 0) ? ($urandom % 256) : 0;
      au = (($urandom % 10) == 0);
      step("R7 random", rx, lk, we, a, d, au);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule